// File: doc/BRIEF.md
# Fractional Nanosecond Baud Generator

This block turns a sampling period written in nanoseconds into the oversampling tick a UART shifter needs. Software writes a divisor word with an integer number of nanoseconds and a fraction counted in 1/255 ns steps. A running time accumulator advances by the reference clock period on every cycle. Each time the accumulator reaches the programmed period, the block subtracts the period and emits a one-cycle sample tick. The remainder is kept, so the average tick rate is exact even when the period is not a whole number of clock cycles.

A separate configuration word selects 8 or 16 samples per bit. Eight is meant for rates of 4 Mbaud and above, sixteen for slower rates. A bit tick is produced together with every 8th or 16th sample tick. The configuration word also holds a 4-bit transmit end-point field, which is passed on to the shifter. Writing either word restarts the timing from a clean state. An integer period of zero parks the generator.

Top module: `bgen_top`

## Requirements
- R1: After reset, sampleTick and bitTick are low and stay low, because the divisor is zero. Sixteen samples per bit are selected and txEndPoint reads 0xF.
- R2: A write with wrSel=0 loads the divisor word. Bits 31:8 hold the integer period I in ns and bits 7:0 hold a fraction x, worth x/255 ns. The period is P = I*255 + x in units of 1/255 ns. The reference clock period is the parameter CLK_STEP in the same units (default 1020, which is 4 ns). When P > CLK_STEP, exactly floor(M*CLK_STEP/P) single-cycle sample ticks appear in the M cycles that follow the write's capture cycle.
- R3: When P <= CLK_STEP and I is not zero, sampleTick is high in every cycle after the write's capture cycle.
- R4: bitTick is high only in a cycle where sampleTick is high. It is high on every Nth sample tick counted from the last restart, where N is 8 or 16 by mode. This gives floor(ticks/N) bit ticks.
- R5: A write with wrSel=1 is compared against two codes, with bits 23:20 of the word ignored in the comparison. The code 0x26731000 selects 8 samples per bit and the code 0x6ef71000 selects 16. Any other configuration word is ignored completely: it changes neither the mode, nor txEndPoint, nor the tick timing.
- R6: txEndPoint equals bits 23:20 of the last accepted configuration word, from the cycle after its capture edge. It does not change when no configuration word is accepted.
- R7: A divisor write or an accepted configuration write restarts the generator. In the cycle after the capture edge both ticks are low, and counting starts again from an empty accumulator and a zero sample count.
- R8: When the integer part I is 0, no sample or bit tick is produced, whatever the fraction holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the divisor word, 1 selects the configuration word |
| wrData | input | 32 | Write data |
| sampleTick | output | 1 | One-cycle oversampling tick |
| bitTick | output | 1 | One-cycle bit strobe, coincident with a sample tick |
| txEndPoint | output | 4 | Transmit end-point field of the accepted configuration |

## Verification
Every result comes from one register stage after the write's capture edge. The cycle right after that edge must show both ticks low. From then on, sample tick number n is due in the first cycle m at which m*CLK_STEP reaches n*P. The bench samples on the falling edge. It treats the falling edge just after the capture edge as the restart check, and counts ticks over the next M falling edges. It compares that count with floor(M*CLK_STEP/P), and compares the bit ticks with the sample count divided by the ratio. The mode and txEndPoint are checked one cycle after a configuration write, and again after a rejected word to show that nothing moved.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
  localparam int WORD_W     = 32;
  localparam int EP_LSB     = 20;
  localparam int EP_W       = 4;
  localparam logic [WORD_W-1:0] CODE_OVS8  = 32'h2673_1000;
  localparam logic [WORD_W-1:0] CODE_OVS16 = 32'h6ef7_1000;
  localparam logic [WORD_W-1:0] CODE_MASK  = ~(32'hF << EP_LSB);
  localparam int RATIO_LO   = 8;
  localparam int RATIO_HI   = 16;
  localparam int RCNT_W     = $clog2(RATIO_HI);

  typedef struct packed {
    logic restart;
    logic run;
    logic wide;
  } ctrlStrobe_t;
endpackage

// File: rtl/bgen_ctrl.sv
module bgen_ctrl
  import bgen_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int PER_W  = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [WORD_W-1:0] wrData,
  output ctrlStrobe_t       strobe,
  output logic [PER_W-1:0]  period,
  output logic [EP_W-1:0]   txEndPoint
);
  localparam int INT_W = WORD_W - FRAC_W;
  localparam logic [PER_W-1:0] FRAC_SCALE = PER_W'((1 << FRAC_W) - 1);

  logic [INT_W-1:0]  newInt;
  logic [FRAC_W-1:0] newFrac;
  logic [PER_W-1:0]  newPeriod;
  logic              hitLo, hitHi, cfgAccept, divWrite;
  logic              runReg, wideReg;

  assign newInt    = wrData[WORD_W-1:FRAC_W];
  assign newFrac   = wrData[FRAC_W-1:0];
  assign newPeriod = PER_W'(newInt) * FRAC_SCALE + PER_W'(newFrac);

  assign hitLo     = (wrData & CODE_MASK) == (CODE_OVS8 & CODE_MASK);
  assign hitHi     = (wrData & CODE_MASK) == (CODE_OVS16 & CODE_MASK);
  assign cfgAccept = wrEn && wrSel && (hitLo || hitHi);
  assign divWrite  = wrEn && !wrSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period <= '0;
      runReg <= 1'b0;
    end else if (divWrite) begin
      period <= newPeriod;
      runReg <= (newInt != '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideReg    <= 1'b1;
      txEndPoint <= CODE_OVS16[EP_LSB +: EP_W];
    end else if (cfgAccept) begin
      wideReg    <= hitHi;
      txEndPoint <= wrData[EP_LSB +: EP_W];
    end
  end

  always_comb begin
    strobe.restart = divWrite || cfgAccept;
    strobe.run     = runReg;
    strobe.wide    = wideReg;
  end
endmodule

// File: rtl/bgen_dp.sv
module bgen_dp
  import bgen_pkg::*;
#(
  parameter int PER_W    = WORD_W,
  parameter int CLK_STEP = 1020
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [PER_W-1:0] period,
  output logic             sampleTick,
  output logic             bitTick
);
  localparam int ACC_W = PER_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(CLK_STEP);

  logic [ACC_W-1:0]  acc, sum, rem, perExt;
  logic [RCNT_W-1:0] sCnt, lastCnt;
  logic              reach;

  assign perExt  = ACC_W'(period);
  assign sum     = acc + STEP;
  assign reach   = sum >= perExt;
  assign rem     = sum - perExt;
  assign lastCnt = strobe.wide ? RCNT_W'(RATIO_HI - 1) : RCNT_W'(RATIO_LO - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc        <= '0;
      sCnt       <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else if (strobe.restart || !strobe.run) begin
      acc        <= '0;
      sCnt       <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else if (reach) begin
      acc        <= (rem >= perExt) ? '0 : rem;
      sampleTick <= 1'b1;
      if (sCnt == lastCnt) begin
        sCnt    <= '0;
        bitTick <= 1'b1;
      end else begin
        sCnt    <= sCnt + 1'b1;
        bitTick <= 1'b0;
      end
    end else begin
      acc        <= sum;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end
  end
endmodule

// File: rtl/bgen_top.sv
module bgen_top
  import bgen_pkg::*;
#(
  parameter int CLK_STEP = 1020,
  parameter int FRAC_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [WORD_W-1:0] wrData,
  output logic              sampleTick,
  output logic              bitTick,
  output logic [EP_W-1:0]   txEndPoint
);
  localparam int PER_W = WORD_W;

  ctrlStrobe_t      strobe;
  logic [PER_W-1:0] period;

  bgen_ctrl #(.FRAC_W(FRAC_W), .PER_W(PER_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobe(strobe), .period(period), .txEndPoint(txEndPoint)
  );

  bgen_dp #(.PER_W(PER_W), .CLK_STEP(CLK_STEP)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .period(period),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );
endmodule

// File: rtl/bgen_chk.sv
module bgen_chk #(
  parameter int CLK_STEP = 1020,
  parameter int PER_W    = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrSel,
  input logic             sampleTick,
  input logic             bitTick,
  input logic [3:0]       txEndPoint,
  input logic [PER_W-1:0] period,
  input logic             run
);
  localparam logic [PER_W:0] TWO_STEP = (PER_W+1)'(2 * CLK_STEP);

  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);                                         // R4

  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (!sampleTick && !bitTick));                 // R7

  AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !sampleTick);                                           // R8

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && ({1'b0, period} >= TWO_STEP)) |=> !sampleTick);   // R2

  AST_EP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(txEndPoint));                                  // R6
endmodule

bind bgen_top bgen_chk #(.CLK_STEP(CLK_STEP), .PER_W(PER_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
  .sampleTick(sampleTick), .bitTick(bitTick), .txEndPoint(txEndPoint),
  .period(period), .run(strobe.run)
);

// File: tb/test_bgen_top.sv
`timescale 1ns/1ps
module test_bgen_top;
  localparam int CLK_STEP = 1020;
  localparam logic [31:0] C8  = 32'h2673_1000;
  localparam logic [31:0] C16 = 32'h6ef7_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic sampleTick, bitTick;
  logic [3:0] txEndPoint;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bgen_top #(.CLK_STEP(CLK_STEP)) i_bgen_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .sampleTick(sampleTick), .bitTick(bitTick), .txEndPoint(txEndPoint)
  );

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at negedge, captured at the next posedge; returns at the negedge after it.
  task automatic wrWord(bit sel, logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countTicks(int m, output int s, output int b);
    s = 0; b = 0;
    for (int k = 0; k < m; k++) begin
      @(negedge clk);
      if (sampleTick) s++;
      if (bitTick) b++;
    end
  endtask

  task automatic runCase(string tag, int ip, int fx, int ratio, int m);
    longint p;
    longint expS;
    int s, b;
    p = longint'(ip) * 255 + fx;
    wrWord(1'b0, {ip[23:0], fx[7:0]});
    check({tag, " R7 restart"}, sampleTick | bitTick, 0);
    countTicks(m, s, b);
    if (ip == 0) expS = 0;
    else if (p <= CLK_STEP) expS = m;
    else expS = (longint'(m) * CLK_STEP) / p;
    check({tag, " samples"}, s, expS);
    check({tag, " R4 bits"}, b, expS / ratio);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int s, b;
    int fr[5] = '{0, 1, 127, 254, 255};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 txEndPoint", txEndPoint, 4'hF);
    countTicks(20, s, b);
    check("R1 no samples", s, 0);
    check("R1 no bits", b, 0);
    // R1: default ratio 16
    runCase("R1 default16 R2", 5, 0, 16, 400);

    // R3: period at or below clock period
    runCase("R3 equal", 4, 0, 16, 200);
    runCase("R3 short", 1, 0, 16, 200);

    // R8: integer zero parks
    runCase("R8 zero", 0, 200, 16, 300);

    // R5 / R6: codes and end-point field
    wrWord(1'b1, C8);
    check("R6 ep 8x", txEndPoint, 4'h7);
    wrWord(1'b1, 32'h2673_1001);
    check("R5 junk keeps ep", txEndPoint, 4'h7);
    runCase("R5 junk keeps 8x", 7, 3, 8, 400);
    wrWord(1'b1, C8 & 32'hFF0F_FFFF);
    check("R6 ep cleared", txEndPoint, 4'h0);
    runCase("R5 cleared ep still 8x", 6, 50, 8, 400);
    wrWord(1'b1, C16);
    check("R6 ep 16x", txEndPoint, 4'hF);
    runCase("R5 16x", 6, 50, 16, 400);

    // R2 sweep over integer and fraction
    for (int ip = 1; ip <= 40; ip++) begin
      for (int j = 0; j < 5; j++) begin
        wrWord(1'b1, (ip % 2) ? C8 : C16);
        runCase("R2 sweep", ip, fr[j], (ip % 2) ? 8 : 16, 400);
      end
    end
    runCase("R2 slow", 62, 127, 16, 800);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule